// File: doc/BRIEF.md
# ALU and Shifter Function Unit

A purely combinational function unit for a narrow register datapath. It receives two operand words, A and B, and a 4-bit function select, and it returns one result word together with four status flags: signed overflow, carry, negative and zero. Inside it are three parts working side by side: an adder fed through per-bit operand conditioning, a bitwise logic circuit, and a one-position shifter that acts on B. An output selector then picks which of these drives the result.

The adder always computes A + Y + cin. Y is B, the complement of B, all zeros or all ones, chosen by two bits of the select. A third select bit is the carry-in. This one conditioning path gives the unit pass, increment, add, subtract, decrement and the related operations without a separate opcode decoder. The unit drives the result and flags in the same cycle that the operands arrive. Registers and sequencing belong to the surrounding datapath.

Top module: `alu_shift_unit`

## Requirements
- R1: With fsel = 0000 the result equals A; with fsel = 0001 it equals A + 1 modulo 2^W.
- R2: With fsel = 0010 the result is A + B; with fsel = 0011 it is A + B + 1 (modulo 2^W).
- R3: With fsel = 0100 the result is A + ~B; with fsel = 0101 it is A + ~B + 1, i.e. A − B.
- R4: With fsel = 0110 the result is A − 1 (A plus all ones); with fsel = 0111 it is A.
- R5: For fsel[3] = 0, carry equals the carry out of the W-bit sum A + Y + fsel[0].
- R6: For fsel[3] = 0, overflow is set exactly when that sum, read as two's complement, falls outside the signed W-bit range.
- R7: With fsel[3:2] = 10 the result is bitwise: 1000 AND, 1001 OR, 1010 XOR, 1011 NOT A.
- R8: With fsel = 1100 or 1111 the result is B unchanged.
- R9: With fsel = 1101 the result is B shifted right by one, with a 0 filling the MSB.
- R10: With fsel = 1110 the result is B shifted left by one, with a 0 filling the LSB.
- R11: Whenever fsel[3] = 1 (logic or shift), carry and overflow are both 0.
- R12: Negative equals the result MSB; zero is 1 exactly when every result bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | Operand A |
| b_in | input | W | Operand B (also the shifter source) |
| fsel | input | 4 | Function select {mode, s1, s0, cin} |
| f_out | output | W | Selected result |
| ovf_o | output | 1 | Signed overflow of the addition |
| cry_o | output | 1 | Carry out of the addition |
| neg_o | output | 1 | Result MSB |
| zero_o | output | 1 | Result is all zeros |

## Verification
Every one of the sixteen function codes is applied to each operand pair, so a fault in any single select bit shows up as a wrong code. Directed pairs target the edges of the adder: zero operands, the 7F/80 boundaries that expose signed overflow in both directions, and all-ones operands that ripple a carry through every bit. Complementary bit patterns such as 55/AA and 0F/F0 tell AND, OR and XOR apart and show which way the shifter moves each bit. Pseudo-random pairs then fill in the carry and overflow combinations that the directed pairs miss.

// File: rtl/fu_pkg.sv
package fu_pkg;
    localparam int FSEL_W = 4;

    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_PASS2 = 2'b11
    } shift_sel_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOT = 2'b11
    } logic_sel_e;
endpackage

// File: rtl/fu_arith.sv
module fu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         s1,
    input  logic         s0,
    input  logic         cin,
    output logic [W-1:0] g,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] y;
    logic [W:0]   sum;

    // per-bit conditioning of B: y = b&s0 | ~b&s1
    for (genvar i = 0; i < W; i++) begin : g_cond
        assign y[i] = (b[i] & s0) | (~b[i] & s1);
    end

    always_comb begin
        sum  = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin};
        g    = sum[W-1:0];
        cout = sum[W];
        // same-sign operands giving a different-sign result
        ovf  = (a[MSB] == y[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/fu_logic.sv
module fu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] h
);
    import fu_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (logic_sel_e'(sel))
                LG_AND:  h[i] = a[i] & b[i];
                LG_OR:   h[i] = a[i] | b[i];
                LG_XOR:  h[i] = a[i] ^ b[i];
                default: h[i] = ~a[i];
            endcase
        end
    end
endmodule

// File: rtl/fu_shift.sv
module fu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] s
);
    import fu_pkg::*;

    localparam logic FILL = 1'b0;

    always_comb begin
        unique case (shift_sel_e'(sel))
            SH_RIGHT: s = {FILL, b[W-1:1]};
            SH_LEFT:  s = {b[W-2:0], FILL};
            default:  s = b;
        endcase
    end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0]             a_in,
    input  logic [W-1:0]             b_in,
    input  logic [fu_pkg::FSEL_W-1:0] fsel,
    output logic [W-1:0]             f_out,
    output logic                     ovf_o,
    output logic                     cry_o,
    output logic                     neg_o,
    output logic                     zero_o
);
    typedef struct packed {
        logic [W-1:0] f;
        logic         v;
        logic         c;
        logic         n;
        logic         z;
    } result_t;

    logic [W-1:0] arith_g;
    logic [W-1:0] logic_h;
    logic [W-1:0] shift_s;
    logic         arith_c;
    logic         arith_v;
    logic         mode_logic;
    logic         mf_sel;
    result_t      res_d;

    assign mode_logic = fsel[3];
    assign mf_sel     = fsel[3] & fsel[2];

    fu_arith #(.W(W)) arith_i (
        .a    (a_in),
        .b    (b_in),
        .s1   (fsel[2]),
        .s0   (fsel[1]),
        .cin  (fsel[0]),
        .g    (arith_g),
        .cout (arith_c),
        .ovf  (arith_v)
    );

    fu_logic #(.W(W)) logic_i (
        .a   (a_in),
        .b   (b_in),
        .sel (fsel[1:0]),
        .h   (logic_h)
    );

    fu_shift #(.W(W)) shift_i (
        .b   (b_in),
        .sel (fsel[1:0]),
        .s   (shift_s)
    );

    always_comb begin
        res_d = '0;
        if (mf_sel) begin
            res_d.f = shift_s;
        end else if (mode_logic) begin
            res_d.f = logic_h;
        end else begin
            res_d.f = arith_g;
            res_d.c = arith_c;
            res_d.v = arith_v;
        end
        res_d.n = res_d.f[W-1];
        res_d.z = (res_d.f == '0);
    end

    assign f_out  = res_d.f;
    assign ovf_o  = res_d.v;
    assign cry_o  = res_d.c;
    assign neg_o  = res_d.n;
    assign zero_o = res_d.z;
endmodule

// File: rtl/alu_shift_unit_chk.sv
module alu_shift_unit_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [3:0]   fsel,
    input logic [W-1:0] f_out,
    input logic         ovf_o,
    input logic         cry_o,
    input logic         neg_o,
    input logic         zero_o
);
    logic known;
    assign known = !$isunknown({a_in, b_in, fsel});

    always_comb begin
        if (known && fsel == 4'b0000) begin
            assert_pass_a_R1: assert (f_out == a_in && !cry_o && !ovf_o)
                else $error("pass A mismatch");
        end
        if (known && fsel == 4'b0111) begin
            assert_wrap_carry_R5: assert (cry_o && f_out == a_in)
                else $error("A+all-ones+1 must carry and return A");
        end
        if (known && fsel == 4'b1110) begin
            assert_shl_R10: assert (f_out == {b_in[W-2:0], 1'b0})
                else $error("shift left mismatch");
        end
        if (known && fsel == 4'b1101) begin
            assert_shr_R9: assert (f_out == {1'b0, b_in[W-1:1]})
                else $error("shift right mismatch");
        end
        if (known && fsel[3]) begin
            assert_flags_clear_R11: assert (!cry_o && !ovf_o)
                else $error("carry/overflow set on non-arithmetic op");
        end
        if (known && zero_o) begin
            assert_zero_not_neg_R12: assert (!neg_o && f_out == '0)
                else $error("zero flag with nonzero result");
        end
    end
endmodule

bind alu_shift_unit alu_shift_unit_chk #(.W(W)) chk_i (
    .a_in   (a_in),
    .b_in   (b_in),
    .fsel   (fsel),
    .f_out  (f_out),
    .ovf_o  (ovf_o),
    .cry_o  (cry_o),
    .neg_o  (neg_o),
    .zero_o (zero_o)
);

// File: tb/alu_shift_unit_tb_top.sv
module alu_shift_unit_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [3:0]   fsel = '0;
    logic [W-1:0] f_out;
    logic         ovf_o, cry_o, neg_o, zero_o;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    alu_shift_unit #(.W(W)) dut_i (
        .a_in   (a_in),
        .b_in   (b_in),
        .fsel   (fsel),
        .f_out  (f_out),
        .ovf_o  (ovf_o),
        .cry_o  (cry_o),
        .neg_o  (neg_o),
        .zero_o (zero_o)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input int av, input int bv, input int fv);
        int y, cin, sum, sa, sy, ss, ef, ec, ev;
        string rt, ct;
        cin = fv & 1;
        ec = 0;
        ev = 0;
        if ((fv & 8) == 0) begin
            case ((fv >> 1) & 3)
                0: begin y = 0;          rt = "R1"; end
                1: begin y = bv;         rt = "R2"; end
                2: begin y = 255 - bv;   rt = "R3"; end
                default: begin y = 255;  rt = "R4"; end
            endcase
            sum = av + y + cin;
            ef  = sum % 256;
            ec  = (sum > 255) ? 1 : 0;
            sa  = (av > 127) ? av - 256 : av;
            sy  = (y > 127) ? y - 256 : y;
            ss  = sa + sy + cin;
            ev  = (ss > 127 || ss < -128) ? 1 : 0;
            ct  = "R5";
        end else if ((fv & 4) == 0) begin
            rt = "R7";
            ct = "R11";
            case (fv & 3)
                0: ef = av & bv;
                1: ef = av | bv;
                2: ef = av ^ bv;
                default: ef = 255 - av;
            endcase
        end else begin
            ct = "R11";
            case (fv & 3)
                1: begin ef = bv / 2;         rt = "R9";  end
                2: begin ef = (bv * 2) % 256; rt = "R10"; end
                default: begin ef = bv;       rt = "R8";  end
            endcase
        end
        @(posedge clk);
        #1;
        a_in = W'(av);
        b_in = W'(bv);
        fsel = 4'(fv);
        @(negedge clk);
        cmp(rt, $sformatf("F fs=%0d a=%0h b=%0h", fv, av, bv), int'(f_out), ef);
        cmp(ct, "C", int'(cry_o), ec);
        cmp((ct == "R5") ? "R6" : "R11", "V", int'(ovf_o), ev);
        cmp("R12", "N", int'(neg_o), (ef > 127) ? 1 : 0);
        cmp("R12", "Z", int'(zero_o), (ef == 0) ? 1 : 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        int pa[10] = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h80, 8'h55, 8'h0F, 8'h01, 8'hFF, 8'h7F};
        int pb[10] = '{8'h00, 8'h01, 8'h01, 8'h80, 8'h01, 8'hAA, 8'hF0, 8'hFF, 8'hFF, 8'h80};
        // idle state with all-zero inputs: result 0, zero set (R1, R12)
        run_case(0, 0, 0);
        for (int p = 0; p < 10; p++) begin
            for (int f = 0; f < 16; f++) run_case(pa[p], pb[p], f);
        end
        seed = 32'h1234_5678;
        for (int r = 0; r < 40; r++) begin
            seed ^= seed << 13;
            seed ^= seed >> 17;
            seed ^= seed << 5;
            for (int f = 0; f < 16; f++) run_case(int'(seed & 255), int'((seed >> 8) & 255), f);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule